// File: doc/BRIEF.md
# Filter Coefficient and Control Loader

This block fills a filter's coefficient store and its control word. It has two sources. In host mode an external master writes through a chip-select, write-strobe, address and data interface. In stand-alone mode the block reads a complete coefficient set on its own from a byte-wide external memory. In that mode it drives the addresses itself, flags the transfer with a busy output and pulses a write strobe that slave loaders can follow.

The coefficient store holds two banks. The filter datapath reads one entry at a time through a bank select and an index. The shared 8-bit address pin is modelled as an input bus, an output bus and an output-enable. The write strobe pin is modelled as an input and a separate output.

The sequencer has four states. LD_BOOT is entered on reset and left at the first clock edge: it goes to LD_READY when `src_host` is high and to LD_ISSUE when it is low. LD_ISSUE drives a memory address and always moves on to LD_CAPTURE. LD_CAPTURE takes the returned byte. From there the sequencer goes back to LD_ISSUE with the next address, or to LD_READY after byte address 255. LD_READY is final until the next reset, and host writes are taken only there.

Top module: `coef_loader`

## Requirements
- R1: The source is sampled in the first clock after reset release. If `src_host` is low, `busy` and `addr_oe` are high from that edge until the load ends. If it is high, both stay low and no load takes place.
- R2: During an automatic load `addr_out` walks byte addresses 0 to 255 in order. Each address is held for two cycles (issue, then capture), so `busy` is high for exactly 512 cycles and falls after the capture of address 255.
- R3: In the automatic load the byte read at an even address is the low half of coefficient (address>>1) and the byte at the following odd address is its high half. The byte is taken from `data_in[7:0]`. Indices 0 to 63 form the lower bank and 64 to 127 the upper bank.
- R4: `wen_out_n` is low for exactly the capture cycle of each byte during the load and high at all other times.
- R5: A host write happens on a clock edge only when `src_host` is high, the loader is in LD_READY, and both `cs_n` and `wen_n` are low. If either strobe is high, nothing changes.
- R6: With `ccs` high a host write loads all 16 bits of `data_in` into `ctrl_word`, whatever the level of `byte_n`. With `ccs` low it writes the coefficient store.
- R7: In word mode (`byte_n` high) a coefficient write stores `data_in` at index `addr_in[6:0]`, and `addr_in[7]` has no effect.
- R8: In byte mode (`byte_n` low) a write with `addr_in[0]`=0 only holds `data_in[7:0]` as a low byte, and the stored entry stays unchanged. A following write with `addr_in[0]`=1 stores {`data_in[7:0]`, held byte} at index `addr_in[7:1]`.
- R9: In stand-alone mode `byte_n` has no effect on the load, and host strobes change neither the store nor `ctrl_word`.
- R10: `rd_coef` shows entry {`bank_sel`, `rd_idx`} combinationally.
- R11: While reset is low, every coefficient entry and `ctrl_word` read zero, `busy` and `addr_oe` are low, and `wen_out_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts a stand-alone load |
| src_host | input | 1 | 1 = host writes, 0 = automatic load from byte memory |
| byte_n | input | 1 | Host mode: 0 = byte transfers, 1 = 16-bit words |
| cs_n | input | 1 | Active-low chip select |
| wen_n | input | 1 | Active-low host write strobe |
| ccs | input | 1 | Write target: 0 = coefficient, 1 = control word |
| addr_in | input | 8 | Host address |
| data_in | input | 16 | Host data, or memory byte on bits 7:0 |
| bank_sel | input | 1 | Read bank: 0 = lower, 1 = upper |
| rd_idx | input | 6 | Coefficient index within the bank |
| addr_out | output | 8 | Byte address sent to the external memory |
| addr_oe | output | 1 | High while the address pins are driven |
| wen_out_n | output | 1 | Active-low strobe to slave loaders |
| busy | output | 1 | High during the automatic load |
| rd_coef | output | 16 | Selected coefficient |
| ctrl_word | output | 16 | Control register |

## Verification
Load outputs are due one clock after reset release. From then on the bench predicts, for every cycle k, an address of k/2 and a strobe that is low on odd k. It drops `busy` in cycle 512. A host write takes effect on the edge between driving and the next falling edge, so the bench checks the store at that falling edge. Reads are combinational and are sampled 1 ns after the index is set. Every input is driven and every output sampled on falling edges, so each check lands a fixed, counted number of edges after its stimulus.

// File: rtl/coef_loader_pkg.sv
package coef_loader_pkg;
    typedef enum logic [1:0] {
        LD_BOOT,
        LD_ISSUE,
        LD_CAPTURE,
        LD_READY
    } ld_state_t;
endpackage

// File: rtl/coef_fsm.sv
module coef_fsm
    import coef_loader_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_host,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_cap,
    output logic              host_ready,
    output logic              busy,
    output logic              addr_oe,
    output logic              wen_out_n
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    ld_state_t state, state_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_BOOT;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            LD_BOOT:    state_nxt = src_host ? LD_READY : LD_ISSUE;
            LD_ISSUE:   state_nxt = LD_CAPTURE;
            LD_CAPTURE: state_nxt = (fetch_addr == LAST_ADDR) ? LD_READY : LD_ISSUE;
            LD_READY:   state_nxt = LD_READY;
        endcase
    end

    // address walker: advances when a capture is not the last one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            fetch_addr <= '0;
        else if (state == LD_CAPTURE && fetch_addr != LAST_ADDR)
            fetch_addr <= fetch_addr + 1'b1;
    end

    // outputs
    always_comb begin
        busy       = 1'b0;
        addr_oe    = 1'b0;
        wen_out_n  = 1'b1;
        fetch_cap  = 1'b0;
        host_ready = 1'b0;
        unique case (state)
            LD_BOOT: begin
            end
            LD_ISSUE: begin
                busy    = 1'b1;
                addr_oe = 1'b1;
            end
            LD_CAPTURE: begin
                busy      = 1'b1;
                addr_oe   = 1'b1;
                wen_out_n = 1'b0;
                fetch_cap = 1'b1;
            end
            LD_READY: begin
                host_ready = src_host;
            end
        endcase
    end
endmodule

// File: rtl/coef_write_path.sv
module coef_write_path #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_ready,
    input  logic              cs_n,
    input  logic              wen_n,
    input  logic              ccs,
    input  logic              byte_n,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    input  logic              fetch_cap,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              coef_we,
    output logic [ADDR_W-2:0] coef_idx,
    output logic [DATA_W-1:0] coef_wdata,
    output logic              ctrl_we
);
    localparam int BYTE_W = DATA_W / 2;
    localparam int IDX_W  = ADDR_W - 1;

    logic              host_wr;
    logic              use_byte;
    logic [ADDR_W-1:0] byte_addr;
    logic [BYTE_W-1:0] byte_val;
    logic [BYTE_W-1:0] lo_hold;

    always_comb begin
        host_wr   = host_ready && !cs_n && !wen_n;
        use_byte  = fetch_cap || (host_wr && !ccs && !byte_n);
        byte_addr = fetch_cap ? fetch_addr : addr_in;
        byte_val  = data_in[BYTE_W-1:0];
        ctrl_we   = host_wr && ccs;
        if (use_byte) begin
            coef_we    = byte_addr[0];
            coef_idx   = byte_addr[ADDR_W-1:1];
            coef_wdata = {byte_val, lo_hold};
        end else begin
            coef_we    = host_wr && !ccs;
            coef_idx   = addr_in[IDX_W-1:0];
            coef_wdata = data_in;
        end
    end

    // low half waits here until its partner byte arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lo_hold <= '0;
        else if (use_byte && !byte_addr[0])
            lo_hold <= byte_val;
    end
endmodule

// File: rtl/coef_store.sv
module coef_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coef_we,
    input  logic [IDX_W-1:0]  coef_idx,
    input  logic [DATA_W-1:0] coef_wdata,
    input  logic              ctrl_we,
    input  logic [DATA_W-1:0] ctrl_wdata,
    input  logic              bank_sel,
    input  logic [IDX_W-2:0]  rd_idx,
    output logic [DATA_W-1:0] rd_coef,
    output logic [DATA_W-1:0] ctrl_word
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (coef_we) begin
            mem[coef_idx] <= coef_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctrl_word <= '0;
        else if (ctrl_we) ctrl_word <= ctrl_wdata;
    end

    assign rd_coef = mem[{bank_sel, rd_idx}];
endmodule

// File: rtl/coef_loader.sv
module coef_loader #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                src_host,
    input  logic                byte_n,
    input  logic                cs_n,
    input  logic                wen_n,
    input  logic                ccs,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic                bank_sel,
    input  logic [ADDR_W-3:0]   rd_idx,
    output logic [ADDR_W-1:0]   addr_out,
    output logic                addr_oe,
    output logic                wen_out_n,
    output logic                busy,
    output logic [DATA_W-1:0]   rd_coef,
    output logic [DATA_W-1:0]   ctrl_word
);
    localparam int IDX_W = ADDR_W - 1;

    logic              fetch_cap;
    logic              host_ready;
    logic              coef_we;
    logic [IDX_W-1:0]  coef_idx;
    logic [DATA_W-1:0] coef_wdata;
    logic              ctrl_we;

    coef_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_host   (src_host),
        .fetch_addr (addr_out),
        .fetch_cap  (fetch_cap),
        .host_ready (host_ready),
        .busy       (busy),
        .addr_oe    (addr_oe),
        .wen_out_n  (wen_out_n)
    );

    coef_write_path #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_ready (host_ready),
        .cs_n       (cs_n),
        .wen_n      (wen_n),
        .ccs        (ccs),
        .byte_n     (byte_n),
        .addr_in    (addr_in),
        .data_in    (data_in),
        .fetch_cap  (fetch_cap),
        .fetch_addr (addr_out),
        .coef_we    (coef_we),
        .coef_idx   (coef_idx),
        .coef_wdata (coef_wdata),
        .ctrl_we    (ctrl_we)
    );

    coef_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .coef_we    (coef_we),
        .coef_idx   (coef_idx),
        .coef_wdata (coef_wdata),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (data_in),
        .bank_sel   (bank_sel),
        .rd_idx     (rd_idx),
        .rd_coef    (rd_coef),
        .ctrl_word  (ctrl_word)
    );
endmodule

// File: rtl/coef_loader_chk.sv
module coef_loader_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wen_n,
    input logic              busy,
    input logic              addr_oe,
    input logic              wen_out_n,
    input logic [ADDR_W-1:0] addr_out,
    input logic [DATA_W-1:0] ctrl_word
);
    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && addr_out != $past(addr_out))
            |-> addr_out == $past(addr_out) + 1'b1);

    // R2
    load_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(addr_out) == {ADDR_W{1'b1}});

    // R4
    strobe_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_out_n |-> busy);

    // R4
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wen_out_n |=> wen_out_n);

    // R1
    drive_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> busy);

    // R9
    ctrl_hold_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_word));

    // R5
    no_strobe_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || wen_n) |=> $stable(ctrl_word));
endmodule

bind coef_loader coef_loader_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wen_n     (wen_n),
    .busy      (busy),
    .addr_oe   (addr_oe),
    .wen_out_n (wen_out_n),
    .addr_out  (addr_out),
    .ctrl_word (ctrl_word)
);

// File: tb/coef_loader_bench.sv
`timescale 1ns/1ps
module coef_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_host = 1'b0;
    logic        byte_n = 1'b1;
    logic        cs_n = 1'b1;
    logic        wen_n = 1'b1;
    logic        ccs = 1'b0;
    logic [7:0]  addr_in = '0;
    logic [15:0] host_data = '0;
    logic [15:0] data_in;
    logic        bank_sel = 1'b0;
    logic [5:0]  rd_idx = '0;
    logic [7:0]  addr_out;
    logic        addr_oe, wen_out_n, busy;
    logic [15:0] rd_coef, ctrl_word;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rom_byte(input logic [7:0] a);
        return 8'((int'(a) * 37 + 11) ^ (int'(a) >> 3));
    endfunction

    function automatic logic [15:0] wval(input int i);
        return 16'(i * 16'h0123) ^ 16'h5A5A;
    endfunction

    assign data_in = src_host ? host_data : {8'hC3, rom_byte(addr_out)};

    coef_loader u_coef_loader (
        .clk(clk), .rst_n(rst_n), .src_host(src_host), .byte_n(byte_n),
        .cs_n(cs_n), .wen_n(wen_n), .ccs(ccs), .addr_in(addr_in),
        .data_in(data_in), .bank_sel(bank_sel), .rd_idx(rd_idx),
        .addr_out(addr_out), .addr_oe(addr_oe), .wen_out_n(wen_out_n),
        .busy(busy), .rd_coef(rd_coef), .ctrl_word(ctrl_word)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_entry(input int idx, output logic [15:0] v);
        bank_sel = idx[6];
        rd_idx   = idx[5:0];
        #1;
        v = rd_coef;
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic host_write(input logic c, input logic [7:0] a,
                              input logic [15:0] d, input logic bm_n);
        ccs = c; addr_in = a; host_data = d; byte_n = bm_n;
        cs_n = 1'b0; wen_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wen_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] exp16;
        int          bad;

        // ---------- stand-alone phase ----------
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 busy", busy, 0);
        check("R11 addr_oe", addr_oe, 0);
        check("R11 wen_out_n", wen_out_n, 1);
        check("R11 ctrl", ctrl_word, 0);
        bad = 0;
        for (int i = 0; i < 128; i++) begin
            read_entry(i, v);
            if (v !== 16'h0) bad++;
        end
        check("R11 store zero", bad, 0);

        rst_n = 1'b1;
        check("R1 boot busy", busy, 0);
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            byte_n = k[0] ^ k[3];            // R9 toggling must not matter
            check("R1 busy", busy, 1);
            check("R1 addr_oe", addr_oe, 1);
            check("R2 addr", addr_out, 32'(k / 2));
            check("R4 strobe", wen_out_n, (k % 2 == 0) ? 1 : 0);
        end
        @(negedge clk);
        check("R2 busy end", busy, 0);
        check("R1 oe end", addr_oe, 0);
        check("R4 strobe end", wen_out_n, 1);

        // R3 / R10 contents over both banks
        for (int i = 0; i < 128; i++) begin
            read_entry(i, v);
            check("R3 R10 entry", v, {rom_byte(8'(2*i+1)), rom_byte(8'(2*i))});
        end

        // R9 host strobes ignored in stand-alone mode
        host_write(1'b1, 8'h00, 16'hAAAA, 1'b1);
        check("R9 ctrl", ctrl_word, 0);
        host_write(1'b0, 8'h05, 16'h1234, 1'b1);
        read_entry(5, v);
        check("R9 entry", v, {rom_byte(8'd11), rom_byte(8'd10)});

        // ---------- host phase ----------
        rst_n = 1'b0;
        src_host = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        bad = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (busy !== 1'b0 || addr_oe !== 1'b0 || wen_out_n !== 1'b1) bad++;
        end
        check("R1 host no load", bad, 0);
        read_entry(77, v);
        check("R11 cleared", v, 0);

        // R7 word mode, top address bit toggled
        for (int i = 0; i < 128; i++)
            host_write(1'b0, {i[0] ^ i[2], 7'(i)}, wval(i), 1'b1);
        for (int i = 0; i < 128; i++) begin
            read_entry(i, v);
            check("R7 R10 word", v, wval(i));
        end

        // R6 control word in byte mode takes all bits
        host_write(1'b1, 8'h3C, 16'hBEEF, 1'b0);
        check("R6 ctrl", ctrl_word, 32'hBEEF);
        read_entry(60, v);
        check("R6 store untouched", v, wval(60));

        // R5 single strobe does nothing
        ccs = 1'b1; host_data = 16'h1111; cs_n = 1'b0; wen_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
        check("R5 cs only", ctrl_word, 32'hBEEF);
        ccs = 1'b0; addr_in = 8'h03; byte_n = 1'b1; host_data = 16'h0000; wen_n = 1'b0;
        @(negedge clk);
        wen_n = 1'b1;
        read_entry(3, v);
        check("R5 wen only", v, wval(3));

        // R8 byte mode
        for (int i = 0; i < 128; i++) begin
            host_write(1'b0, {7'(i), 1'b0}, {8'hEE, 8'(i * 7 + 1)}, 1'b0);
            read_entry(i, v);
            check("R8 low held", v, wval(i));
            host_write(1'b0, {7'(i), 1'b1}, {8'h77, ~8'(i)}, 1'b0);
            read_entry(i, v);
            exp16 = {~8'(i), 8'(i * 7 + 1)};
            check("R8 pair", v, exp16);
        end

        finish_run();
    end
endmodule